// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block sits in front of a 32K-word by 32-bit synchronous memory array. It captures a 15-bit start address and then steps through the three remaining word addresses of a four-beat burst. The first beat always uses the captured address. The following beats are produced by a 2-bit beat counter. Only the two lowest address bits take part in the sequence; the upper thirteen bits stay exactly as captured for the whole burst.

There are two active-low load strobes. The processor strobe counts only while the chip enable is high. The controller strobe loads regardless of the chip enable. The active-low advance input steps the burst by one beat per clock. A select input chooses between linear order (the beat count is added to the low bits) and interleaved order (the beat count is XORed into the low bits). The select is captured together with the address. All outputs come straight from registers.

Top module: `burst_seq_gen`

## Requirements
- R1: When `adsc_n` is low at a rising edge, `addr_in` is loaded whatever the value of `ce`. After that edge, `addr_out` equals the loaded address and `addr_vld` is 1.
- R2: When `adsp_n` is low at a rising edge, the address is loaded only if `ce` is 1. With `ce` at 0 and `adsc_n` high, `addr_out` and `addr_vld` are left unchanged.
- R3: With `order_sel` at 0 when the address was loaded (linear order), beat k has low bits (start + k) mod 4. For example, start 2 gives 2,3,0,1.
- R4: With `order_sel` at 1 when the address was loaded (interleaved order), beat k has low bits start XOR k. For example, start 1 gives 1,0,3,2.
- R5: The burst moves one beat per rising edge only while `adv_n` is low. While `adv_n` is high and no load occurs, `addr_out` holds its value.
- R6: After the fourth beat, a further advance returns to the start address. Bits 14..2 of `addr_out` never change outside a load.
- R7: A load in the same cycle as `adv_n` low wins: `addr_out` becomes the new address and no advance step is applied.
- R8: Synchronous active-high `rst` sets `addr_out` to 0 and `addr_vld` to 0. Advances before the first load leave both unchanged, and once set, `addr_vld` stays at 1 until the next reset.
- R9: A change of `order_sel` after the load does not alter the order of the burst in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| adsp_n | input | 1 | Processor load strobe, active low, gated by `ce` |
| adsc_n | input | 1 | Controller load strobe, active low, not gated |
| ce | input | 1 | Chip enable, active high, qualifies `adsp_n` |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | Burst order: 1 interleaved, 0 linear; captured at load |
| addr_in | input | 15 | Start word address |
| addr_out | output | 15 | Current beat word address (registered) |
| addr_vld | output | 1 | High once an address has been loaded since reset |

## Verification
Every result is due one clock after the edge that caused it. A load shows the new address on `addr_out` after that same edge. An advance step shows the next beat after its edge, and a reset clears both outputs after one edge. The bench drives its inputs on the falling edge and updates its reference model just after the rising edge, using only the values it drove. It compares `addr_out` and `addr_vld` at the following falling edge, so each check looks exactly one register stage behind its stimulus. Directed sequences cover the wrap, the gated processor strobe, load-over-advance priority and an order change in mid-burst. These are followed by a long stretch of weighted random strobes, advances and order changes.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int BEAT_W = 2;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

  function automatic logic [BEAT_W-1:0] beat_offset(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] beat,
    input burst_order_e      ord
  );
    logic [BEAT_W-1:0] res;
    if (ord == ORD_INTERLEAVE) res = start ^ beat;
    else                       res = start + beat;
    return res;
  endfunction

endpackage

// File: rtl/bsg_strobe_dec.sv
module bsg_strobe_dec (
  input  logic adsp_n,
  input  logic adsc_n,
  input  logic ce,
  input  logic adv_n,
  input  logic vld,
  output logic load,
  output logic step
);
  logic cpu_ld;
  logic ctl_ld;

  always_comb begin
    cpu_ld = ~adsp_n & ce;
    ctl_ld = ~adsc_n;
    load   = cpu_ld | ctl_ld;
    step   = ~load & ~adv_n & vld;
  end
endmodule

// File: rtl/bsg_beat_ctr.sv
module bsg_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  burst_order_e      ord_in,
  output logic [BEAT_W-1:0] beat_nxt,
  output burst_order_e      ord_q,
  output logic              vld_q
);
  logic [BEAT_W-1:0] beat_q;

  always_comb beat_nxt = beat_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q <= '0;
      ord_q  <= ORD_LINEAR;
      vld_q  <= 1'b0;
    end else if (load) begin
      beat_q <= '0;
      ord_q  <= ord_in;
      vld_q  <= 1'b1;
    end else if (step) begin
      beat_q <= beat_nxt;
    end
  end
endmodule

// File: rtl/bsg_addr_reg.sv
module bsg_addr_reg
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [BEAT_W-1:0] beat_nxt,
  input  burst_order_e      ord,
  output logic [ADDR_W-1:0] addr_q
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] lo_nxt;
  logic [HI_W-1:0]   hi_base;

  always_comb begin
    hi_base = base_q[ADDR_W-1:BEAT_W];
    lo_nxt  = beat_offset(base_q[BEAT_W-1:0], beat_nxt, ord);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      addr_q <= '0;
    end else if (load) begin
      base_q <= addr_in;
      addr_q <= addr_in;
    end else if (step) begin
      addr_q <= {hi_base, lo_nxt};
    end
  end
endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              ce,
  input  logic              adv_n,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_vld
);
  logic              load;
  logic              step;
  logic [BEAT_W-1:0] beat_nxt;
  burst_order_e      ord_q;

  bsg_strobe_dec dec_i (
    .adsp_n (adsp_n),
    .adsc_n (adsc_n),
    .ce     (ce),
    .adv_n  (adv_n),
    .vld    (addr_vld),
    .load   (load),
    .step   (step)
  );

  bsg_beat_ctr ctr_i (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .step     (step),
    .ord_in   (burst_order_e'(order_sel)),
    .beat_nxt (beat_nxt),
    .ord_q    (ord_q),
    .vld_q    (addr_vld)
  );

  bsg_addr_reg #(.ADDR_W(ADDR_W)) areg_i (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .step     (step),
    .addr_in  (addr_in),
    .beat_nxt (beat_nxt),
    .ord      (ord_q),
    .addr_q   (addr_out)
  );
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              adsp_n,
  input logic              adsc_n,
  input logic              ce,
  input logic              adv_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic              addr_vld
);
  logic ld_seen;
  always_comb ld_seen = (~adsp_n & ce) | ~adsc_n;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (addr_out == '0) && !addr_vld);  // R8

  AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (rst)
    ld_seen |=> (addr_out == $past(addr_in)) && addr_vld);  // R1

  AST_HOLD_NO_ADV: assert property (@(posedge clk) disable iff (rst)
    (!ld_seen && adv_n) |=> $stable(addr_out));  // R5

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
    !ld_seen |=> $stable(addr_out[ADDR_W-1:2]));  // R6

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
    addr_vld |=> addr_vld);  // R8

  AST_IDLE_BEFORE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!addr_vld && !ld_seen) |=> !addr_vld && $stable(addr_out));  // R2
endmodule

bind burst_seq_gen burst_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .adsp_n   (adsp_n),
  .adsc_n   (adsc_n),
  .ce       (ce),
  .adv_n    (adv_n),
  .addr_in  (addr_in),
  .addr_out (addr_out),
  .addr_vld (addr_vld)
);

// File: tb/burst_seq_gen_tb_top.sv
`timescale 1ns/1ps
module burst_seq_gen_tb_top;
  localparam int AW = 15;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          adsp_n = 1'b1;
  logic          adsc_n = 1'b1;
  logic          ce = 1'b0;
  logic          adv_n = 1'b1;
  logic          order_sel = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic          addr_vld;

  int errors = 0;
  int checks = 0;

  logic [AW-1:0] m_base = '0;
  logic [AW-1:0] m_addr = '0;
  logic          m_vld = 1'b0;
  logic          m_ord = 1'b0;
  int            m_beat = 0;

  always #4 clk = ~clk;

  burst_seq_gen #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .adsp_n(adsp_n), .adsc_n(adsc_n), .ce(ce),
    .adv_n(adv_n), .order_sel(order_sel), .addr_in(addr_in),
    .addr_out(addr_out), .addr_vld(addr_vld)
  );

  function automatic logic [1:0] exp_low(input logic [1:0] s, input int k, input logic ilv);
    int v;
    if (ilv) v = int'(s) ^ (k % 4);
    else     v = (int'(s) + k) % 4;
    return v[1:0];
  endfunction

  task automatic check(input string tag);
    checks++;
    if (addr_out !== m_addr || addr_vld !== m_vld) begin
      errors++;
      $display("FAIL %s: addr=%h vld=%b expected addr=%h vld=%b",
               tag, addr_out, addr_vld, m_addr, m_vld);
    end
  endtask

  task automatic cycle(input logic p, input logic c, input logic e, input logic a,
                       input logic o, input logic [AW-1:0] ad, input string tag);
    logic ld;
    adsp_n = p; adsc_n = c; ce = e; adv_n = a; order_sel = o; addr_in = ad;
    @(posedge clk);
    #1;
    ld = (!p && e) || !c;
    if (ld) begin
      m_base = ad; m_addr = ad; m_beat = 0; m_ord = o; m_vld = 1'b1;
    end else if (!a && m_vld) begin
      m_beat = m_beat + 1;
      m_addr = {m_base[AW-1:2], exp_low(m_base[1:0], m_beat, m_ord)};
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
  end

  initial begin
    logic pr, cr, er, ar, orr;
    logic [AW-1:0] adr;
    string tg;
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R8 reset state");
    // advance before any load: nothing happens
    cycle(1, 1, 1, 0, 0, 15'h0155, "R8 adv before load");
    // processor strobe with chip enable low is ignored
    cycle(0, 1, 0, 1, 0, 15'h1234, "R2 gated adsp");
    // controller strobe loads with ce low; linear start 2
    cycle(1, 0, 0, 1, 0, 15'h4AB2, "R1 adsc load");
    cycle(1, 1, 0, 0, 0, 15'h0000, "R3 linear beat1");
    cycle(1, 1, 0, 0, 0, 15'h0000, "R3 linear beat2");
    cycle(1, 1, 0, 0, 0, 15'h0000, "R3 linear beat3");
    cycle(1, 1, 0, 0, 0, 15'h0000, "R6 wrap to start");
    cycle(1, 1, 0, 1, 0, 15'h0000, "R5 hold");
    cycle(1, 1, 0, 1, 0, 15'h0000, "R5 hold again");
    // processor strobe with ce high; interleaved start 1
    cycle(0, 1, 1, 1, 1, 15'h3C71, "R2 adsp load");
    cycle(1, 1, 1, 0, 0, 15'h0000, "R9 order change beat1");
    cycle(1, 1, 1, 0, 0, 15'h0000, "R4 interleave beat2");
    cycle(1, 1, 1, 0, 1, 15'h0000, "R4 interleave beat3");
    cycle(1, 1, 1, 0, 1, 15'h0000, "R6 interleave wrap");
    // load beats advance in the same cycle
    cycle(1, 0, 1, 0, 0, 15'h7FFF, "R7 load over adv");
    cycle(1, 1, 1, 0, 0, 15'h0000, "R3 linear from 3");
    // reset mid-burst
    rst = 1'b1;
    @(posedge clk);
    #1;
    m_addr = '0; m_vld = 1'b0; m_beat = 0; m_base = '0;
    @(negedge clk);
    rst = 1'b0;
    check("R8 reset mid burst");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      pr  = ($urandom % 6) != 0;
      cr  = ($urandom % 8) != 0;
      er  = ($urandom % 2) != 0;
      ar  = ($urandom % 3) == 0;
      orr = ($urandom % 2) != 0;
      adr = AW'($urandom);
      if ((!pr && er) || !cr) tg = "R1 random load";
      else if (!pr)            tg = "R2 random gated";
      else if (ar)             tg = "R5 random hold";
      else if (m_ord)          tg = "R4 random step";
      else                     tg = "R3 random step";
      cycle(pr, cr, er, ar, orr, adr, tg);
    end
    summary();
  end
endmodule